// File: doc/BRIEF.md
# Memory Bus Cycle Sequencer

This block sits on the processor side of a plain synchronous memory bus. A client hands it one request at a time. Each request carries a byte address, a direction flag and, for stores, one data byte. The block turns the request into a bus transaction that spans several clock cycles. It drives the address lines, an active-low read strobe or an active-low write strobe, and the outgoing data lines with their enable. It then stretches the strobe phase until the memory raises its ready line.

A read puts the address out first and then lowers the read strobe. It waits for ready, latches the incoming byte at that edge, and raises the strobe again. Once the strobe is high the fetched byte is valid on the result output. A write puts the address out and lowers the write strobe. It enables the data lines from the following cycle until ready is seen, then raises the strobe and stops driving data. A one-cycle completion pulse ends every transaction. A busy flag covers the whole time from acceptance to that pulse.

Top module: `membus_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, both strobes are high (inactive), the data enable `bus_data_oe` is low, and `busy` and `done` are low.
- R2: A request (`req_valid` high at a clock edge) is taken only when `busy` is low. A request presented while `busy` is high starts no transaction and changes no bus output.
- R3: Read order: in the first cycle after acceptance the address is on `bus_addr` and both strobes are high. In the next cycle `bus_rd_n` goes low. It stays low until the wait phase ends, and it is high again in the `done` cycle.
- R4: Write order: in the first cycle after acceptance both strobes are high. In the second cycle `bus_wr_n` is low and `bus_data_oe` is still low. From the third cycle `bus_wr_n` stays low and `bus_data_oe` is high with the request byte on `bus_data_out`, until the wait phase ends. In the `done` cycle `bus_wr_n` is high and `bus_data_oe` is low.
- R5: `mem_ready` is sampled only in the wait phase, which starts in the third cycle after acceptance. A high `mem_ready` during the address or strobe cycle is ignored. A transaction with k cycles of low `mem_ready` in the wait phase lasts 4+k cycles, counted from the first `busy` cycle to the `done` cycle inclusive.
- R6: For a read, `rdata` in the `done` cycle equals `bus_data_in` as sampled at the clock edge where `mem_ready` was seen high in the wait phase.
- R7: `done` is high for exactly one cycle, the last `busy` cycle. In the cycle after it, `busy` and `done` are both low.
- R8: `bus_addr` equals the accepted request address from the first `busy` cycle through the `done` cycle and does not change in between. The address is a byte address: one address selects one 8-bit data byte.
- R9: `bus_rd_n` and `bus_wr_n` are never low together. `bus_data_oe` is high only while `bus_wr_n` is low.
- R10: A write transaction leaves `rdata` unchanged; it keeps the byte from the most recent read (zero after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Byte to store |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Byte fetched by the last read |
| bus_addr | output | ADDR_W | Address lines |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_data_out | output | DATA_W | Outgoing data lines |
| bus_data_oe | output | 1 | Enable for outgoing data lines |
| bus_data_in | input | DATA_W | Incoming data lines |
| mem_ready | input | 1 | Memory ready, ends the wait phase |

## Verification
The hardest cases to reach are those where the timing of `mem_ready` relative to the phases matters. One is ready arriving early, during the strobe cycle, where it must be ignored. The other is the exact edge at which the read byte is latched. The bench memory model counts strobe-low cycles and raises ready after a chosen number of wait cycles, or already in the strobe cycle for the early case. It shows the true byte only while ready is high and the inverted byte otherwise, so a capture one edge off is caught. A second request held high in the middle of a transaction covers the case of requests that must be refused while busy.

// File: rtl/membus_pkg.sv
package membus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_ADDR    = 3'd1,
        PH_STROBE  = 3'd2,
        PH_WAIT    = 3'd3,
        PH_RELEASE = 3'd4
    } phase_e;

    typedef struct packed {
        phase_e ph;
        logic   is_wr;
        logic   rd_n;
        logic   wr_n;
        logic   oe;
        logic   done;
    } seq_state_t;

endpackage

// File: rtl/membus_fsm.sv
module membus_fsm
    import membus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic mem_ready,
    output logic accept,
    output logic capture,
    output logic busy,
    output logic done,
    output logic rd_n,
    output logic wr_n,
    output logic oe
);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        accept  = 1'b0;
        capture = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    accept     = 1'b1;
                    st_d.ph    = PH_ADDR;
                    st_d.is_wr = req_write;
                end
            end
            PH_ADDR:   st_d.ph = PH_STROBE;
            PH_STROBE: st_d.ph = PH_WAIT;
            PH_WAIT: begin
                if (mem_ready) begin
                    st_d.ph = PH_RELEASE;
                    capture = !st_q.is_wr;
                end
            end
            PH_RELEASE: st_d.ph = PH_IDLE;
            default:    st_d.ph = PH_IDLE;
        endcase
        // strobes and enable are registered: decode from the next phase
        st_d.rd_n = !(!st_d.is_wr && (st_d.ph == PH_STROBE || st_d.ph == PH_WAIT));
        st_d.wr_n = !( st_d.is_wr && (st_d.ph == PH_STROBE || st_d.ph == PH_WAIT));
        st_d.oe   = st_d.is_wr && (st_d.ph == PH_WAIT);
        st_d.done = (st_d.ph == PH_RELEASE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, is_wr: 1'b0, rd_n: 1'b1, wr_n: 1'b1, oe: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.ph != PH_IDLE);
    assign done = st_q.done;
    assign rd_n = st_q.rd_n;
    assign wr_n = st_q.wr_n;
    assign oe   = st_q.oe;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R9
    AST_OE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> !wr_n); // R9
    AST_STROBE_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> $past(st_q.ph) == PH_ADDR); // R3
    AST_RELEASE_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_n) || $rose(wr_n)) |-> ($past(mem_ready) && done)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R7
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R2

endmodule

// File: rtl/membus_dpath.sv
module membus_dpath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic              oe,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data_out,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } dp_t;

    dp_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (accept) begin
            dp_d.addr  = req_addr;
            dp_d.wdata = req_wdata;
        end
        if (capture) begin
            dp_d.rdata = bus_data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign addr     = dp_q.addr;
    assign data_out = oe ? dp_q.wdata : '0;
    assign rdata    = dp_q.rdata;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rdata)); // R10

endmodule

// File: rtl/membus_seq.sv
module membus_seq #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    input  logic [DATA_W-1:0] bus_data_in,
    input  logic              mem_ready
);

    logic accept;
    logic capture;

    membus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .mem_ready (mem_ready),
        .accept    (accept),
        .capture   (capture),
        .busy      (busy),
        .done      (done),
        .rd_n      (bus_rd_n),
        .wr_n      (bus_wr_n),
        .oe        (bus_data_oe)
    );

    membus_dpath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dpath (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .capture     (capture),
        .oe          (bus_data_oe),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .bus_data_in (bus_data_in),
        .addr        (bus_addr),
        .data_out    (bus_data_out),
        .rdata       (rdata)
    );

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(bus_addr)); // R8
    AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $rose(bus_rd_n)) |-> rdata == $past(bus_data_in)); // R6

endmodule

// File: tb/sim_membus_seq.sv
module sim_membus_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done;
    logic [7:0]  rdata;
    logic [15:0] bus_addr;
    logic        bus_rd_n, bus_wr_n, bus_data_oe;
    logic [7:0]  bus_data_out;
    logic [7:0]  bus_data_in = '0;
    logic        mem_ready = 1'b0;

    always #4 clk = ~clk;

    membus_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
        .bus_data_in(bus_data_in), .mem_ready(mem_ready)
    );

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory model and reference image
    logic [7:0] model_mem [int];
    logic [7:0] ref_mem   [int];
    int cur_waits = 0;
    int low_cnt = 0;

    function automatic logic [7:0] peek_model(input int a);
        return model_mem.exists(a) ? model_mem[a] : 8'h3C;
    endfunction
    function automatic logic [7:0] peek_ref(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'h3C;
    endfunction

    always @(negedge clk) begin
        if (!bus_rd_n || !bus_wr_n) low_cnt = low_cnt + 1;
        else low_cnt = 0;
        mem_ready = (low_cnt != 0) && (low_cnt >= 2 + cur_waits);
        if (!bus_rd_n && mem_ready) bus_data_in = peek_model(int'(bus_addr));
        else bus_data_in = ~peek_model(int'(bus_addr));
        if (!bus_wr_n && bus_data_oe && mem_ready) model_mem[int'(bus_addr)] = bus_data_out;
    end

    // scoreboard
    typedef struct {
        bit          wr;
        logic [15:0] addr;
        logic [7:0]  data;
        int          cycles;
    } item_t;
    item_t sbq[$];
    item_t cur;
    bit    run_mon = 1'b0;
    bit    prev_done = 1'b0;
    int    phase = 0;
    logic [7:0] last_read = 8'h00;

    always @(negedge clk) begin
        if (run_mon) begin
            if (prev_done)
                chk(!busy && !done, "R7", "idle after done", {busy, done}, 0);
            if (busy) phase = phase + 1;
            else phase = 0;
            if (busy && phase == 1) begin
                if (sbq.size() == 0) begin
                    chk(0, "R2", "transaction with no accepted request", 1, 0);
                end else begin
                    cur = sbq[0];
                    chk(bus_addr == cur.addr, "R8", "address first cycle", bus_addr, cur.addr);
                    chk(bus_rd_n && bus_wr_n, "R3", "strobes high in address cycle",
                        {bus_rd_n, bus_wr_n}, 2'b11);
                end
            end
            if (busy && phase == 2) begin
                chk(bus_rd_n == cur.wr && bus_wr_n == !cur.wr && !bus_data_oe,
                    cur.wr ? "R4" : "R3", "strobe cycle", {bus_rd_n, bus_wr_n, bus_data_oe},
                    {cur.wr, !cur.wr, 1'b0});
            end
            if (busy && phase >= 3 && !done) begin
                chk(bus_rd_n == cur.wr && bus_wr_n == !cur.wr && bus_data_oe == cur.wr,
                    cur.wr ? "R4" : "R3", "wait phase", {bus_rd_n, bus_wr_n, bus_data_oe},
                    {cur.wr, !cur.wr, cur.wr});
                if (cur.wr)
                    chk(bus_data_out == cur.data, "R4", "write data", bus_data_out, cur.data);
                chk(bus_addr == cur.addr, "R8", "address held", bus_addr, cur.addr);
            end
            if (done) begin
                chk(busy, "R7", "busy during done", busy, 1);
                chk(phase == cur.cycles, "R5", "transaction length", phase, cur.cycles);
                chk(bus_rd_n && bus_wr_n && !bus_data_oe, "R7", "released at done",
                    {bus_rd_n, bus_wr_n, bus_data_oe}, 3'b110);
                chk(bus_addr == cur.addr, "R8", "address at done", bus_addr, cur.addr);
                if (cur.wr) begin
                    chk(rdata == last_read, "R10", "rdata after write", rdata, last_read);
                    chk(peek_model(int'(cur.addr)) == cur.data, "R4", "byte stored",
                        peek_model(int'(cur.addr)), cur.data);
                end else begin
                    chk(rdata == cur.data, "R6", "read data", rdata, cur.data);
                    last_read = cur.data;
                end
                if (sbq.size() != 0) void'(sbq.pop_front());
            end
            prev_done = done;
        end
    end

    task automatic issue(input bit wr, input logic [15:0] a, input logic [7:0] d,
                         input int waits, input bit intrude);
        item_t it;
        while (busy) @(negedge clk);
        it.wr = wr;
        it.addr = a;
        it.data = wr ? d : peek_ref(int'(a));
        it.cycles = 4 + (waits > 0 ? waits : 0);
        if (wr) ref_mem[int'(a)] = d;
        cur_waits = waits;
        sbq.push_back(it);
        req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (intrude) begin
            // R2: second request while busy must be refused
            req_write = !wr; req_addr = ~a; req_wdata = ~d; req_valid = 1'b1;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (sbq.size() != 0) @(negedge clk);
        if (intrude) begin
            repeat (3) @(negedge clk);
            chk(!busy && bus_rd_n && bus_wr_n, "R2", "no extra transaction",
                {busy, bus_rd_n, bus_wr_n}, 3'b011);
        end
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "R5", "watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk(bus_rd_n && bus_wr_n && !bus_data_oe && !busy && !done, "R1", "reset state",
            {bus_rd_n, bus_wr_n, bus_data_oe, busy, done}, 5'b11000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_rd_n && bus_wr_n && !bus_data_oe && !busy && !done, "R1", "after reset",
            {bus_rd_n, bus_wr_n, bus_data_oe, busy, done}, 5'b11000);
        chk(rdata == 8'h00, "R10", "rdata reset", rdata, 0);
        run_mon = 1'b1;

        issue(1'b1, 16'h0010, 8'hA5, 0, 1'b0);   // R10 write keeps reset rdata
        issue(1'b0, 16'h0020, 8'h00, 0, 1'b0);   // unwritten byte
        issue(1'b0, 16'h0010, 8'h00, 0, 1'b0);   // R6 read back
        issue(1'b1, 16'h1234, 8'h5A, 3, 1'b0);   // R5 write with waits
        issue(1'b1, 16'h0011, 8'h77, 0, 1'b0);   // R8 neighbour byte
        issue(1'b0, 16'h1234, 8'h00, 5, 1'b0);
        issue(1'b0, 16'h0011, 8'h00, -1, 1'b0);  // R5 early ready ignored
        issue(1'b1, 16'h0011, 8'h99, -1, 1'b0);  // R4 early ready on write
        issue(1'b0, 16'h0011, 8'h00, 1, 1'b1);   // R2 request while busy
        issue(1'b1, 16'hFFFF, 8'hC3, 2, 1'b1);
        issue(1'b0, 16'hFFFF, 8'h00, 0, 1'b0);
        issue(1'b0, 16'h0000, 8'h00, 7, 1'b0);
        for (int i = 0; i < 6; i++)
            issue(1'b1, 16'h0200 + 16'(i), 8'(i * 37 + 11), i % 3, 1'b0);
        for (int i = 0; i < 6; i++)
            issue(1'b0, 16'h0200 + 16'(i), 8'h00, (i * 2) % 5, 1'b0);

        repeat (3) @(negedge clk);
        report();
        $finish;
    end

endmodule